// File: doc/BRIEF.md
# DMA Channel Command and Status Register Block

This block is the software-visible control face of one DMA channel. A host writes and reads 32-bit words at a byte offset on a simple bus. Writing the command word produces one-cycle pulses that tell the channel datapath to start, continue, stop after draining, abort, flush its FIFO or reset itself. The same word also carries the commands that clear the sticky status flags.

The control word holds the channel configuration: transfer mode, direction, burst, FIFO disable and the two byte-swap options. It also holds eight interrupt enables. Each enable has its own set bit and its own clear bit, so software can change one enable without reading the register first.

The datapath reports events as single-cycle pulses: done, link complete, transfer error (together with three 2-bit error codes) and end. The block turns each event into a sticky flag and combines the flags with the enables to drive one interrupt line. The DMA engine, its FIFO and the bus master are outside this block.

Top module: `dmach_regs`

## Requirements
- R1: Writing the command word (offset 0x0) raises one output pulse per set bit. The pulses are asserted in the cycle after the write and last exactly one cycle. Bit 0 is start, bit 1 continue, bit 2 stop-after-drain, bit 3 abort, bit 4 FIFO flush and bit 31 channel reset. Bit 5 clears the link flag and bit 7 clears the done flag. Reading offset 0x0 returns zero.
- R2: The control word is at offset 0x4. Enable k (k = 0..7) is set by bit 31-2k and cleared by bit 30-2k. A write leaves every enable whose two bits are both 0 unchanged. On readback, each enable appears at its set-bit position and the clear-bit positions read 0. Enable 0 is the global interrupt enable, enable 3 the done enable and enable 6 the link-complete enable.
- R3: When a single write has both the set bit and the clear bit of one pair at 1, that enable ends up cleared.
- R4: Control bits 2:0 hold the mode, bit 3 the direction (1 = device to memory), bit 4 the memory-side swap, bit 6 the device-side swap, bit 14 burst enable and bit 15 FIFO disable. These fields read back at the same positions and drive the configuration outputs.
- R5: While the channel is active, a control write leaves the configuration fields unchanged but still applies its enable set and clear bits.
- R6: Start or continue makes the channel active. Abort, channel reset or a done event makes it inactive. Stop does not, on its own, end the active state. When a done event and a start arrive in the same cycle, the start wins.
- R7: The status word is at offset 0x8, with done at bit 25 and link complete at bit 19. Each of these flags is set by its event and stays set until its own clear command. An event that arrives in the same cycle as the clear leaves the flag set. Writes to the status offset have no effect.
- R8: Status bit 9 is a sticky transfer-error flag and bit 8 a sticky end flag. A transfer-error event captures the link error code into bits 5:4, the memory code into bits 3:2 and the device code into bits 1:0. These flags and codes clear only on channel reset.
- R9: The interrupt output is the global enable ANDed with the OR of (done AND done enable), (link AND link enable) and the transfer-error flag. Status bit 31 reads the same value.
- R10: A channel reset clears every sticky flag, every error code, every enable and the active state, and keeps the configuration fields.
- R11: After the synchronous reset, all outputs and all readable words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_off | input | ADDR_W | Byte offset; writes with nonzero low two bits are ignored |
| reg_wr | input | 1 | Write enable for the addressed word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed word (combinational) |
| ev_done | input | 1 | Datapath done event pulse |
| ev_link | input | 1 | Datapath link-complete event pulse |
| ev_xerr | input | 1 | Datapath transfer-error event pulse |
| ev_end | input | 1 | Datapath end event pulse |
| err_mem | input | 2 | Memory-side error code (1 bus, 2 retry, 3 other) |
| err_dev | input | 2 | Device-side error code |
| err_link | input | 2 | Link-fetch error code |
| go_start | output | 1 | Start command pulse |
| go_cont | output | 1 | Continue command pulse |
| go_stop | output | 1 | Stop-after-drain command pulse |
| go_abort | output | 1 | Abort command pulse |
| go_fifo_rst | output | 1 | FIFO flush command pulse |
| go_chan_rst | output | 1 | Channel reset command pulse |
| chan_active | output | 1 | Channel is running |
| irq | output | 1 | Interrupt request |
| cfg_mode | output | 3 | Transfer mode |
| cfg_dir | output | 1 | Direction, 1 = device to memory |
| cfg_burst | output | 1 | Burst enable |
| cfg_fifo_off | output | 1 | FIFO disable |
| cfg_swap_dev | output | 1 | Device-side byte swap |
| cfg_swap_mem | output | 1 | Memory-side byte swap |

## Verification
Directed sequences come first. They place the set and clear bits of one pair in the same word, apply a control write while the channel runs, and send an event in the same cycle as its clear command. These cases separate the priority rules from ordinary behaviour. Long random runs follow, mixing command, control and status writes with sparse event pulses and rare channel resets. A reference model kept in the bench predicts every pulse, the active bit, the interrupt line and both readback words after each cycle. The random runs expose wrong interactions between enables and flags that single directed writes miss, such as an interrupt raised without the global enable, or configuration accepted in the cycle a run begins.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

    localparam int DATA_W = 32;
    localparam int N_IE   = 8;

    // enable indices; pair k uses set bit DATA_W-1-2k and clear bit DATA_W-2-2k
    localparam int IE_GLOBAL = 0;
    localparam int IE_DONE   = 3;
    localparam int IE_LINK   = 6;

    // command word bit positions
    localparam int OPB_START    = 0;
    localparam int OPB_CONT     = 1;
    localparam int OPB_STOP     = 2;
    localparam int OPB_ABORT    = 3;
    localparam int OPB_FRST     = 4;
    localparam int OPB_CLR_LINK = 5;
    localparam int OPB_CLR_DONE = 7;
    localparam int OPB_CHAN_RST = 31;

    // control word field positions
    localparam int CFB_FIFO_OFF = 15;
    localparam int CFB_BURST    = 14;
    localparam int CFB_SWAP_DEV = 6;
    localparam int CFB_SWAP_MEM = 4;
    localparam int CFB_DIR      = 3;

    // status word bit positions
    localparam int STB_IRQ  = 31;
    localparam int STB_DONE = 25;
    localparam int STB_LINK = 19;
    localparam int STB_XERR = 9;
    localparam int STB_END  = 8;

    // word indices (byte offset / 4)
    localparam int REG_OP   = 0;
    localparam int REG_CTRL = 1;
    localparam int REG_STAT = 2;

    typedef enum logic [2:0] {
        MODE_NORMAL     = 3'd0,
        MODE_CONT       = 3'd1,
        MODE_RING       = 3'd2,
        MODE_LINK_SHORT = 3'd4,
        MODE_LINK_LONG  = 3'd5
    } xfer_mode_e;

    typedef struct packed {
        logic       fifo_off;
        logic       burst;
        logic       swap_dev;
        logic       swap_mem;
        logic       dev_to_mem;
        xfer_mode_e mode;
    } chan_cfg_t;

    typedef struct packed {
        logic chan_rst;
        logic clr_done;
        logic clr_link;
        logic fifo_rst;
        logic abort;
        logic stop;
        logic cont;
        logic start;
    } chan_cmd_t;

    typedef struct packed {
        logic [1:0] link;
        logic [1:0] mem;
        logic [1:0] dev;
    } err_codes_t;

    function automatic chan_cmd_t cmd_from_word(input logic [DATA_W-1:0] w);
        chan_cmd_t c;
        c.chan_rst = w[OPB_CHAN_RST];
        c.clr_done = w[OPB_CLR_DONE];
        c.clr_link = w[OPB_CLR_LINK];
        c.fifo_rst = w[OPB_FRST];
        c.abort    = w[OPB_ABORT];
        c.stop     = w[OPB_STOP];
        c.cont     = w[OPB_CONT];
        c.start    = w[OPB_START];
        return c;
    endfunction

    function automatic chan_cfg_t cfg_from_word(input logic [DATA_W-1:0] w);
        chan_cfg_t c;
        c.fifo_off   = w[CFB_FIFO_OFF];
        c.burst      = w[CFB_BURST];
        c.swap_dev   = w[CFB_SWAP_DEV];
        c.swap_mem   = w[CFB_SWAP_MEM];
        c.dev_to_mem = w[CFB_DIR];
        c.mode       = xfer_mode_e'(w[2:0]);
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] cfg_to_word(input chan_cfg_t c);
        logic [DATA_W-1:0] w;
        w               = '0;
        w[CFB_FIFO_OFF] = c.fifo_off;
        w[CFB_BURST]    = c.burst;
        w[CFB_SWAP_DEV] = c.swap_dev;
        w[CFB_SWAP_MEM] = c.swap_mem;
        w[CFB_DIR]      = c.dev_to_mem;
        w[2:0]          = c.mode;
        return w;
    endfunction

endpackage

// File: rtl/dmach_cmd_decode.sv
module dmach_cmd_decode
    import dmach_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_wr,
    input  logic [DATA_W-1:0] wdata,
    output chan_cmd_t         cmd_now,
    output chan_cmd_t         cmd_q
);

    logic unused_wbits;
    assign unused_wbits = ^wdata;

    assign cmd_now = op_wr ? cmd_from_word(wdata) : '0;

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_now;
    end

    // R1: an outgoing pulse always traces back to a command write one cycle earlier
    a_r1_start_from_write: assert property (@(posedge clk) disable iff (rst)
        cmd_q.start |-> $past(op_wr && wdata[OPB_START]));
    a_r1_rst_from_write: assert property (@(posedge clk) disable iff (rst)
        cmd_q.chan_rst |-> $past(op_wr && wdata[OPB_CHAN_RST]));

endmodule

// File: rtl/dmach_ctrl.sv
module dmach_ctrl
    import dmach_pkg::*;
#(
    parameter int NIE = N_IE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              active,
    input  logic              chan_rst,
    output logic [NIE-1:0]    ie,
    output chan_cfg_t         cfg,
    output logic [DATA_W-1:0] rd_word
);

    for (genvar k = 0; k < NIE; k++) begin : g_pair
        localparam int SB = DATA_W - 1 - 2 * k;
        localparam int CB = SB - 1;
        logic ie_q;

        always_ff @(posedge clk) begin
            if (rst || chan_rst) begin
                ie_q <= 1'b0;
            end else if (ctrl_wr) begin
                if (wdata[CB])      ie_q <= 1'b0;
                else if (wdata[SB]) ie_q <= 1'b1;
            end
        end

        assign ie[k] = ie_q;

        // R3: a clear bit in a control write always leaves the enable low
        a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
            (ctrl_wr && wdata[CB]) |=> !ie_q);
    end

    always_ff @(posedge clk) begin
        if (rst)                     cfg <= '0;
        else if (ctrl_wr && !active) cfg <= cfg_from_word(wdata);
    end

    always_comb begin
        rd_word = cfg_to_word(cfg);
        for (int k = 0; k < NIE; k++) rd_word[DATA_W-1-2*k] = ie[k];
    end

    // R5: configuration fields hold across a control write made while running
    a_r5_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (active && ctrl_wr) |=> $stable(cfg));

endmodule

// File: rtl/dmach_status.sv
module dmach_status
    import dmach_pkg::*;
#(
    parameter int NIE = N_IE
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_cmd_t         cmd_now,
    input  logic              ev_done,
    input  logic              ev_link,
    input  logic              ev_xerr,
    input  logic              ev_end,
    input  err_codes_t        err_in,
    input  logic [NIE-1:0]    ie,
    output logic              active,
    output logic              irq,
    output logic [DATA_W-1:0] rd_word
);

    logic       done_q, link_q, xerr_q, end_q, active_q;
    err_codes_t err_q;
    logic       unused_cmd;

    assign unused_cmd = cmd_now.stop ^ cmd_now.fifo_rst ^ (^ie);

    always_ff @(posedge clk) begin
        if (rst || cmd_now.chan_rst) begin
            done_q <= 1'b0;
            link_q <= 1'b0;
            xerr_q <= 1'b0;
            end_q  <= 1'b0;
            err_q  <= '0;
        end else begin
            if (ev_done)               done_q <= 1'b1;
            else if (cmd_now.clr_done) done_q <= 1'b0;
            if (ev_link)               link_q <= 1'b1;
            else if (cmd_now.clr_link) link_q <= 1'b0;
            if (ev_xerr) begin
                xerr_q <= 1'b1;
                err_q  <= err_in;
            end
            if (ev_end) end_q <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd_now.chan_rst || cmd_now.abort) active_q <= 1'b0;
        else if (cmd_now.start || cmd_now.cont)       active_q <= 1'b1;
        else if (ev_done)                             active_q <= 1'b0;
    end

    assign active = active_q;
    assign irq    = ie[IE_GLOBAL] &
                    ((done_q & ie[IE_DONE]) | (link_q & ie[IE_LINK]) | xerr_q);

    always_comb begin
        rd_word           = '0;
        rd_word[STB_IRQ]  = irq;
        rd_word[STB_DONE] = done_q;
        rd_word[STB_LINK] = link_q;
        rd_word[STB_XERR] = xerr_q;
        rd_word[STB_END]  = end_q;
        rd_word[5:4]      = err_q.link;
        rd_word[3:2]      = err_q.mem;
        rd_word[1:0]      = err_q.dev;
    end

    // R7: the done flag persists unless cleared or reset
    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        (done_q && !cmd_now.clr_done && !cmd_now.chan_rst) |=> done_q);
    // R6: abort always ends the active state
    a_r6_abort_idles: assert property (@(posedge clk) disable iff (rst)
        cmd_now.abort |=> !active_q);
    // R10: channel reset empties all sticky state
    a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
        cmd_now.chan_rst |=> (!done_q && !link_q && !xerr_q && !end_q && !active_q));
    // R9: no interrupt without the global enable
    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        irq |-> ie[IE_GLOBAL]);

endmodule

// File: rtl/dmach_regs.sv
module dmach_regs
    import dmach_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_off,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              ev_done,
    input  logic              ev_link,
    input  logic              ev_xerr,
    input  logic              ev_end,
    input  logic [1:0]        err_mem,
    input  logic [1:0]        err_dev,
    input  logic [1:0]        err_link,
    output logic              go_start,
    output logic              go_cont,
    output logic              go_stop,
    output logic              go_abort,
    output logic              go_fifo_rst,
    output logic              go_chan_rst,
    output logic              chan_active,
    output logic              irq,
    output logic [2:0]        cfg_mode,
    output logic              cfg_dir,
    output logic              cfg_burst,
    output logic              cfg_fifo_off,
    output logic              cfg_swap_dev,
    output logic              cfg_swap_mem
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  word_idx;
    logic              aligned, op_wr, ctrl_wr;
    chan_cmd_t         cmd_now, cmd_q;
    chan_cfg_t         cfg;
    logic [N_IE-1:0]   ie;
    logic [DATA_W-1:0] ctrl_rd, stat_rd;
    err_codes_t        err_in;

    assign word_idx = reg_off[ADDR_W-1:2];
    assign aligned  = (reg_off[1:0] == 2'b00);
    assign op_wr    = reg_wr && aligned && (word_idx == IDX_W'(REG_OP));
    assign ctrl_wr  = reg_wr && aligned && (word_idx == IDX_W'(REG_CTRL));
    assign err_in   = '{link: err_link, mem: err_mem, dev: err_dev};

    dmach_cmd_decode u_cmd (
        .clk     (clk),
        .rst     (rst),
        .op_wr   (op_wr),
        .wdata   (reg_wdata),
        .cmd_now (cmd_now),
        .cmd_q   (cmd_q)
    );

    dmach_ctrl #(.NIE(N_IE)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_wr  (ctrl_wr),
        .wdata    (reg_wdata),
        .active   (chan_active),
        .chan_rst (cmd_now.chan_rst),
        .ie       (ie),
        .cfg      (cfg),
        .rd_word  (ctrl_rd)
    );

    dmach_status #(.NIE(N_IE)) u_stat (
        .clk     (clk),
        .rst     (rst),
        .cmd_now (cmd_now),
        .ev_done (ev_done),
        .ev_link (ev_link),
        .ev_xerr (ev_xerr),
        .ev_end  (ev_end),
        .err_in  (err_in),
        .ie      (ie),
        .active  (chan_active),
        .irq     (irq),
        .rd_word (stat_rd)
    );

    always_comb begin
        case (word_idx)
            IDX_W'(REG_CTRL): reg_rdata = ctrl_rd;
            IDX_W'(REG_STAT): reg_rdata = stat_rd;
            default:          reg_rdata = '0;
        endcase
    end

    assign go_start     = cmd_q.start;
    assign go_cont      = cmd_q.cont;
    assign go_stop      = cmd_q.stop;
    assign go_abort     = cmd_q.abort;
    assign go_fifo_rst  = cmd_q.fifo_rst;
    assign go_chan_rst  = cmd_q.chan_rst;
    assign cfg_mode     = cfg.mode;
    assign cfg_dir      = cfg.dev_to_mem;
    assign cfg_burst    = cfg.burst;
    assign cfg_fifo_off = cfg.fifo_off;
    assign cfg_swap_dev = cfg.swap_dev;
    assign cfg_swap_mem = cfg.swap_mem;

    logic unused_cmdq;
    assign unused_cmdq = cmd_q.clr_done ^ cmd_q.clr_link;

endmodule

// File: tb/dmach_regs_test.sv
`timescale 1ns/100ps
module dmach_regs_test;

    localparam logic [31:0] CFG_MASK = 32'h0000_C05F;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_off = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ev_done = 0, ev_link = 0, ev_xerr = 0, ev_end = 0;
    logic [1:0]  err_mem = 0, err_dev = 0, err_link = 0;
    logic        go_start, go_cont, go_stop, go_abort, go_fifo_rst, go_chan_rst;
    logic        chan_active, irq;
    logic [2:0]  cfg_mode;
    logic        cfg_dir, cfg_burst, cfg_fifo_off, cfg_swap_dev, cfg_swap_mem;

    always #2.5 clk = ~clk;

    dmach_regs uut (
        .clk(clk), .rst(rst), .reg_off(reg_off), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_done(ev_done), .ev_link(ev_link), .ev_xerr(ev_xerr), .ev_end(ev_end),
        .err_mem(err_mem), .err_dev(err_dev), .err_link(err_link),
        .go_start(go_start), .go_cont(go_cont), .go_stop(go_stop),
        .go_abort(go_abort), .go_fifo_rst(go_fifo_rst), .go_chan_rst(go_chan_rst),
        .chan_active(chan_active), .irq(irq), .cfg_mode(cfg_mode), .cfg_dir(cfg_dir),
        .cfg_burst(cfg_burst), .cfg_fifo_off(cfg_fifo_off),
        .cfg_swap_dev(cfg_swap_dev), .cfg_swap_mem(cfg_swap_mem)
    );

    int n_vec  = 0;
    int n_fail = 0;
    bit finished = 0;

    // reference model state
    logic [7:0]  m_ie = '0;
    logic [31:0] m_cfg = '0;
    logic        m_done = 0, m_link = 0, m_xerr = 0, m_end = 0, m_act = 0;
    logic [5:0]  m_err = '0;
    logic [31:0] m_op = '0;

    function automatic logic m_irq();
        return m_ie[0] & ((m_done & m_ie[3]) | (m_link & m_ie[6]) | m_xerr);
    endfunction

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] w = m_cfg;
        for (int k = 0; k < 8; k++) w[31-2*k] = m_ie[k];
        return w;
    endfunction

    function automatic logic [31:0] exp_stat();
        logic [31:0] s = '0;
        s[31] = m_irq(); s[25] = m_done; s[19] = m_link;
        s[9] = m_xerr; s[8] = m_end; s[5:0] = m_err;
        return s;
    endfunction

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R1 pulses"},
            {26'h0, go_chan_rst, go_fifo_rst, go_abort, go_stop, go_cont, go_start},
            {26'h0, m_op[31], m_op[4], m_op[3], m_op[2], m_op[1], m_op[0]});
        chk({tag, " R6 active"}, {31'h0, chan_active}, {31'h0, m_act});
        chk({tag, " R9 irq"}, {31'h0, irq}, {31'h0, m_irq()});
        chk({tag, " R4 cfg ports"},
            {24'h0, cfg_fifo_off, cfg_burst, cfg_swap_dev, cfg_swap_mem, cfg_dir, cfg_mode},
            {24'h0, m_cfg[15], m_cfg[14], m_cfg[6], m_cfg[4], m_cfg[3], m_cfg[2:0]});
        reg_wr = 0; ev_done = 0; ev_link = 0; ev_xerr = 0; ev_end = 0;
        reg_off = 4'h4; #0.4;
        chk({tag, " R2 ctrl read"}, reg_rdata, exp_ctrl());
        reg_off = 4'h8; #0.4;
        chk({tag, " R7 status read"}, reg_rdata, exp_stat());
        reg_off = 4'h0; #0.4;
        chk({tag, " R1 op read"}, reg_rdata, 32'h0);
    endtask

    // ev = {end, xerr, link, done}; errs = {link, mem, dev}
    task automatic step(input string tag, input logic wr, input logic [3:0] off,
                        input logic [31:0] wd, input logic [3:0] ev, input logic [5:0] errs);
        logic [31:0] op;
        logic        ctw, crst;
        logic [7:0]  n_ie;
        logic [31:0] n_cfg;
        logic        n_done, n_link, n_xerr, n_end, n_act;
        logic [5:0]  n_err;
        reg_wr = wr; reg_off = off; reg_wdata = wd;
        {ev_end, ev_xerr, ev_link, ev_done} = ev;
        {err_link, err_mem, err_dev} = errs;
        op   = (wr && off == 4'h0) ? wd : 32'h0;
        ctw  = wr && off == 4'h4;
        crst = op[31];
        n_ie = m_ie;
        if (ctw) begin
            for (int k = 0; k < 8; k++) begin
                if (wd[30-2*k])      n_ie[k] = 1'b0;
                else if (wd[31-2*k]) n_ie[k] = 1'b1;
            end
        end
        if (crst) n_ie = '0;
        n_cfg  = (ctw && !m_act) ? (wd & CFG_MASK) : m_cfg;
        n_done = crst ? 1'b0 : ev[0] ? 1'b1 : op[7] ? 1'b0 : m_done;
        n_link = crst ? 1'b0 : ev[1] ? 1'b1 : op[5] ? 1'b0 : m_link;
        n_xerr = crst ? 1'b0 : ev[2] ? 1'b1 : m_xerr;
        n_err  = crst ? 6'h0 : ev[2] ? errs : m_err;
        n_end  = crst ? 1'b0 : ev[3] ? 1'b1 : m_end;
        n_act  = (crst || op[3]) ? 1'b0 : (op[0] || op[1]) ? 1'b1 : ev[0] ? 1'b0 : m_act;
        @(posedge clk);
        @(negedge clk);
        m_ie = n_ie; m_cfg = n_cfg; m_done = n_done; m_link = n_link;
        m_xerr = n_xerr; m_err = n_err; m_end = n_end; m_act = n_act; m_op = op;
        check_all(tag);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R11 reset");

        // R4: configuration fields
        step("R4 cfg", 1, 4'h4, 32'h0000_C05D, 4'h0, 6'h0);
        chk("R4 mode port", {29'h0, cfg_mode}, 32'd5);
        // R2: set global and done enables, then clear done only
        step("R2 set", 1, 4'h4, 32'h8200_0004, 4'h0, 6'h0);
        step("R2 clear", 1, 4'h4, 32'h0100_0004, 4'h0, 6'h0);
        // R3: set link enable, then set+clear in one word
        step("R3 set", 1, 4'h4, 32'h0208_0004, 4'h0, 6'h0);
        step("R3 both", 1, 4'h4, 32'h000C_0004, 4'h0, 6'h0);
        chk("R3 link enable", {31'h0, reg_rdata[19]}, 32'h0);
        reg_off = 4'h4; #0.4;
        chk("R3 link enable bit", {31'h0, reg_rdata[19]}, 32'h0);
        // R6 / R5: start, config change while running ignored, enables still apply
        step("R6 start", 1, 4'h0, 32'h0000_0001, 4'h0, 6'h0);
        step("R6 idle", 0, 4'h0, 32'h0, 4'h0, 6'h0);
        step("R5 frozen", 1, 4'h4, 32'h0008_0001, 4'h0, 6'h0);
        step("R6 stop", 1, 4'h0, 32'h0000_0004, 4'h0, 6'h0);
        step("R9 done", 0, 4'h0, 32'h0, 4'h1, 6'h0);
        // R7: status write ignored; event beats same-cycle clear; clear works
        step("R7 statwr", 1, 4'h8, 32'hFFFF_FFFF, 4'h0, 6'h0);
        step("R7 link", 0, 4'h0, 32'h0, 4'h2, 6'h0);
        step("R7 race", 1, 4'h0, 32'h0000_0020, 4'h2, 6'h0);
        step("R7 clrdone", 1, 4'h0, 32'h0000_00A0, 4'h0, 6'h0);
        // R8: transfer error codes and end
        step("R8 xerr", 0, 4'h0, 32'h0, 4'hC, 6'b11_10_01);
        // R10: channel reset keeps configuration
        step("R6 cont", 1, 4'h0, 32'h0000_0002, 4'h0, 6'h0);
        step("R10 reset", 1, 4'h0, 32'h8000_0010, 4'h0, 6'h0);

        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] wd;
            logic [3:0]  ev;
            wd = $urandom;
            if ($urandom % 16 != 0) wd[31] = 1'b0;
            ev[0] = ($urandom % 8 == 0);
            ev[1] = ($urandom % 8 == 0);
            ev[2] = ($urandom % 16 == 0);
            ev[3] = ($urandom % 16 == 0);
            step("RND", ($urandom % 2) == 1, 4'(($urandom % 4) * 4), wd, ev, 6'($urandom));
        end

        finished = 1;
        summary();
        $finish;
    end

endmodule